// File: doc/BRIEF.md
# I2C Wiper Controller with Reset and Shutdown

This block is a two-wire bus slave that owns a single 8-bit wiper register for a digitally set resistor ladder. It recognises start and stop conditions on the bus, answers to a 7-bit device address, and accepts either a write transaction or a read transaction. The address has a fixed upper part. Its lowest bit comes from a strap pin, so two such controllers can share one bus.

A write transaction carries an instruction byte and then any number of data bytes. Two instruction bits matter. One forces the wiper back to midscale and blocks the data bytes that follow. The other raises a shutdown flag that disconnects the analog output while the stored code is kept. The instruction stays in force for every data byte until the transaction ends. A read transaction returns the stored code, most significant bit first, as many times as the master acknowledges.

The bus lines are sampled in a system clock domain through synchronisers. The data line is driven only as a pull-low enable, which the open-drain pad turns into a wired-AND with the master.

Top module: `digipot_i2c`

## Requirements
- R1: After reset the wiper code is 0x80, the shutdown flag is 0 and the data line is not pulled low.
- R2: An address byte whose upper seven bits equal {0,1,0,1,1,0,addrStrap} is acknowledged by pulling the data line low during the ninth clock. Bit 0 of the address byte selects read (1) or write (0). Any other address gets no acknowledge, and the rest of that transaction is ignored.
- R3: In a write, the byte after the address is an instruction byte and is acknowledged. Each later data byte is received MSB first, is acknowledged, and becomes the wiper code.
- R4: Several data bytes in one write transaction are each acknowledged, and each one updates the wiper code in turn.
- R5: With instruction bit 6 set, the wiper code becomes 0x80. Data bytes later in the same transaction are acknowledged but leave it at 0x80. The next transaction with bit 6 clear writes normally.
- R6: Instruction bit 5 sets the shutdown flag, and clearing it clears the flag. Neither change alters the stored code. Codes written while the flag is set are stored.
- R7: In a read, the wiper code is driven MSB first right after the address acknowledge. Each master acknowledge is followed by the same code again. A master not-acknowledge releases the bus.
- R8: A start or stop inside a byte aborts the transfer and leaves the register unchanged. After a start the controller matches a new address.
- R9: Instruction bit 7 and bits 4 to 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| addrStrap | input | 1 | Lowest address bit strap |
| sdaPullLow | output | 1 | Pull-low enable for the data line |
| wiperCode | output | 8 | Stored wiper code |
| shutdownOut | output | 1 | Shutdown flag: terminal A open, wiper tied to B |

## Verification
Every code value is written within one long write transaction. A design that commits only the first data byte, or shifts LSB first, would show a wrong code after some byte. The midscale-hold case sends data after a reset instruction: a design that drops the hold when the data arrives would store the data. The combined reset and shutdown instruction is covered too. Aborts are placed in the middle of a byte, as a stop and as a repeated start. A design that commits partial bytes would change the code, and one that is not restarted cleanly would fail to acknowledge the next address. Reads with several master acknowledges would expose a design that does not reload the code or that keeps driving after the not-acknowledge. Both strap values are used, each with a matching and a mismatching address.

// File: rtl/digipot_pkg.sv
package digipot_pkg;
  localparam int BYTE_BITS = 8;
  localparam int RS_BIT = 6;
  localparam int SD_BIT = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_WDATA, ST_RDATA
  } bus_st_t;

  typedef struct packed {
    logic rxBit;
    logic shiftIn;
    logic loadInstr;
    logic writeData;
    logic loadTx;
    logic shiftTx;
    logic endTxn;
  } dp_ctl_t;
endpackage

// File: rtl/digipot_ctrl.sv
module digipot_ctrl
  import digipot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI = 6'b010110
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic addrStrap,
  input  logic [BYTE_BITS-1:0] rxByte,
  input  logic txNext,
  input  logic wiperMsb,
  output dp_ctl_t ctl,
  output logic sdaPullLow,
  output logic sclSync
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startEv, stopEv;
  bus_st_t st, stNxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic ackOn, ackNxt, rdMode, rwNxt, pullNxt;
  logic [6:0] devAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];
  assign sclSync = sclS;
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv = sclS & sclD & ~sdaD & sdaS;
  assign devAddr = {ADDR_HI, addrStrap};

  always_comb begin
    ctl = '0;
    ctl.rxBit = sdaS;
    stNxt = st;
    cntNxt = bitCnt;
    ackNxt = ackOn;
    rwNxt = rdMode;
    pullNxt = sdaPullLow;
    if (startEv || stopEv) begin
      stNxt = startEv ? ST_ADDR : ST_IDLE;
      cntNxt = '0;
      ackNxt = 1'b0;
      pullNxt = 1'b0;
      ctl.endTxn = 1'b1;
    end else if (st == ST_RDATA) begin
      if (sclRise) begin
        if (bitCnt != LAST) cntNxt = bitCnt + 1'b1;
        else if (sdaS) stNxt = ST_IDLE;
        else ackNxt = 1'b1;
      end else if (sclFall) begin
        if (bitCnt == LAST) begin
          if (ackOn) begin
            ctl.loadTx = 1'b1;
            pullNxt = ~wiperMsb;
            cntNxt = '0;
            ackNxt = 1'b0;
          end else begin
            pullNxt = 1'b0;
          end
        end else if (bitCnt != '0) begin
          ctl.shiftTx = 1'b1;
          pullNxt = ~txNext;
        end
      end
    end else if (st != ST_IDLE) begin
      if (sclRise && bitCnt != LAST) begin
        ctl.shiftIn = 1'b1;
        cntNxt = bitCnt + 1'b1;
      end else if (sclFall && bitCnt == LAST) begin
        if (!ackOn) begin
          if (st == ST_ADDR) begin
            if (rxByte[BYTE_BITS-1:1] == devAddr) begin
              pullNxt = 1'b1;
              ackNxt = 1'b1;
              rwNxt = rxByte[0];
            end else begin
              stNxt = ST_IDLE;
            end
          end else begin
            pullNxt = 1'b1;
            ackNxt = 1'b1;
            ctl.loadInstr = (st == ST_INSTR);
            ctl.writeData = (st == ST_WDATA);
          end
        end else begin
          pullNxt = 1'b0;
          ackNxt = 1'b0;
          cntNxt = '0;
          if (st == ST_ADDR) begin
            if (rdMode) begin
              stNxt = ST_RDATA;
              ctl.loadTx = 1'b1;
              pullNxt = ~wiperMsb;
            end else begin
              stNxt = ST_INSTR;
            end
          end else begin
            stNxt = ST_WDATA;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE;
      bitCnt <= '0;
      ackOn <= 1'b0;
      rdMode <= 1'b0;
      sdaPullLow <= 1'b0;
    end else begin
      st <= stNxt;
      bitCnt <= cntNxt;
      ackOn <= ackNxt;
      rdMode <= rwNxt;
      sdaPullLow <= pullNxt;
    end
  end
endmodule

// File: rtl/digipot_dp.sv
module digipot_dp
  import digipot_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  dp_ctl_t ctl,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic txNext,
  output logic wiperMsb,
  output logic [BYTE_BITS-1:0] wiperCode,
  output logic shutdownOut,
  output logic rstHold
);
  localparam logic [BYTE_BITS-1:0] MIDSCALE = BYTE_BITS'(1) << (BYTE_BITS - 1);

  logic [BYTE_BITS-1:0] rxReg, txReg, wiperReg;
  logic shutReg, holdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0;
      txReg <= '0;
      wiperReg <= MIDSCALE;
      shutReg <= 1'b0;
      holdReg <= 1'b0;
    end else begin
      if (ctl.shiftIn) rxReg <= {rxReg[BYTE_BITS-2:0], ctl.rxBit};
      if (ctl.endTxn) holdReg <= 1'b0;
      if (ctl.loadInstr) begin
        holdReg <= rxReg[RS_BIT];
        shutReg <= rxReg[SD_BIT];
        if (rxReg[RS_BIT]) wiperReg <= MIDSCALE;
      end
      if (ctl.writeData && !holdReg) wiperReg <= rxReg;
      if (ctl.loadTx) txReg <= wiperReg;
      else if (ctl.shiftTx) txReg <= {txReg[BYTE_BITS-2:0], 1'b0};
    end
  end

  assign rxByte = rxReg;
  assign txNext = txReg[BYTE_BITS-2];
  assign wiperMsb = wiperReg[BYTE_BITS-1];
  assign wiperCode = wiperReg;
  assign shutdownOut = shutReg;
  assign rstHold = holdReg;
endmodule

// File: rtl/digipot_i2c.sv
module digipot_i2c
  import digipot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI = 6'b010110
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic addrStrap,
  output logic sdaPullLow,
  output logic [BYTE_BITS-1:0] wiperCode,
  output logic shutdownOut
);
  dp_ctl_t ctl;
  logic [BYTE_BITS-1:0] rxByte;
  logic txNext, wiperMsb, sclSync, rstHold;

  digipot_ctrl #(.SYNC_STAGES(SYNC_STAGES), .ADDR_HI(ADDR_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrStrap(addrStrap), .rxByte(rxByte), .txNext(txNext),
    .wiperMsb(wiperMsb), .ctl(ctl), .sdaPullLow(sdaPullLow),
    .sclSync(sclSync)
  );

  digipot_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxByte(rxByte),
    .txNext(txNext), .wiperMsb(wiperMsb), .wiperCode(wiperCode),
    .shutdownOut(shutdownOut), .rstHold(rstHold)
  );
endmodule

// File: rtl/digipot_i2c_chk.sv
module digipot_i2c_chk (
  input logic clk,
  input logic rstN,
  input logic sclSync,
  input logic sdaPullLow,
  input logic [7:0] wiperCode,
  input logic shutdownOut,
  input logic rstHold
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (wiperCode == 8'h80 && !shutdownOut && !sdaPullLow));

  p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclSync);

  p_code_commit_at_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wiperCode) |-> sdaPullLow);

  p_hold_pins_mid_r5: assert property (@(posedge clk) disable iff (!rstN)
    rstHold |-> wiperCode == 8'h80);

  p_shutdown_at_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(shutdownOut) |-> sdaPullLow);
endmodule

bind digipot_i2c digipot_i2c_chk u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaPullLow(sdaPullLow),
  .wiperCode(wiperCode), .shutdownOut(shutdownOut), .rstHold(rstHold)
);

// File: tb/digipot_i2c_test.sv
module digipot_i2c_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [5:0] DEV_HI = 6'b010110;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic strap = 1'b0;
  logic sdaPullLow, shutdownOut, sdaLine;
  logic [7:0] wiperCode;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  assign sdaLine = sdaM & ~sdaPullLow;

  digipot_i2c uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .addrStrap(strap), .sdaPullLow(sdaPullLow), .wiperCode(wiperCode),
    .shutdownOut(shutdownOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; q(); sclM = 1'b1; q(); sdaM = 1'b0; q(); sclM = 1'b0; q();
  endtask

  task automatic busStop();
    sdaM = 1'b0; q(); sclM = 1'b1; q(); sdaM = 1'b1; q();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; q(); sclM = 1'b1; q(); q(); sclM = 1'b0; q();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; q(); sclM = 1'b1; q(); ack = ~sdaLine; q(); sclM = 1'b0; q();
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] d);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); sclM = 1'b1; q(); d[i] = sdaLine; q(); sclM = 1'b0; q();
    end
    sdaM = ~mAck; q(); sclM = 1'b1; q(); q(); sclM = 1'b0; q(); sdaM = 1'b1;
  endtask

  function automatic logic [7:0] addrByte(input logic bit0, input logic rd);
    return {DEV_HI, bit0, rd};
  endfunction

  task automatic writeTxn(input logic [7:0] instr, input bit withData,
                          input logic [7:0] code, input string tag);
    logic a0, a1, a2;
    busStart();
    writeByte(addrByte(strap, 1'b0), a0);
    writeByte(instr, a1);
    a2 = 1'b1;
    if (withData) writeByte(code, a2);
    busStop();
    check(a0 && a1 && a2, tag, {a0, a1, a2}, 3'b111);
  endtask

  task automatic readTxn(input logic [7:0] exp, input string tag);
    logic a0;
    logic [7:0] d;
    busStart();
    writeByte(addrByte(strap, 1'b1), a0);
    check(a0, {tag, " addr ack"}, a0, 1);
    for (int k = 0; k < 3; k++) begin
      readByte(k != 2, d);
      check(d == exp, tag, d, exp);
    end
    busStop();
    check(!sdaPullLow, {tag, " released"}, sdaPullLow, 0);
  endtask

  initial begin
    logic a0, a1, a2;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(wiperCode == 8'h80, "R1 code", wiperCode, 8'h80);
    check(!shutdownOut, "R1 shutdown", shutdownOut, 0);
    check(!sdaPullLow, "R1 pull", sdaPullLow, 0);

    busStart();
    writeByte(addrByte(~strap, 1'b0), a0);
    writeByte(8'h00, a1);
    writeByte(8'h33, a2);
    busStop();
    check(!a0 && !a1 && !a2, "R2 mismatch no ack", {a0, a1, a2}, 0);
    check(wiperCode == 8'h80, "R2 mismatch ignored", wiperCode, 8'h80);

    busStart();
    writeByte(addrByte(strap, 1'b0), a0);
    writeByte(8'h00, a1);
    check(a0 && a1, "R2 R3 addr/instr ack", {a0, a1}, 2'b11);
    for (int i = 0; i < 256; i++) begin
      v = 8'((i * 77 + 13) & 255);
      writeByte(v, a2);
      check(a2, "R4 data ack", a2, 1);
      check(wiperCode == v, "R3 R4 code", wiperCode, v);
    end
    busStop();

    for (int i = 0; i < 12; i++) begin
      v = 8'((i * 53 + 200) & 255);
      writeTxn(8'h00, 1, v, "R3 write");
      readTxn(v, "R7 read");
    end

    busStart();
    writeByte(addrByte(strap, 1'b0), a0);
    writeByte(8'h40, a1);
    check(wiperCode == 8'h80, "R5 reset instr", wiperCode, 8'h80);
    writeByte(8'h11, a2);
    check(a2 && wiperCode == 8'h80, "R5 held 1", wiperCode, 8'h80);
    writeByte(8'h22, a2);
    check(a2 && wiperCode == 8'h80, "R5 held 2", wiperCode, 8'h80);
    busStop();
    writeTxn(8'h00, 1, 8'h5A, "R5 new txn ack");
    check(wiperCode == 8'h5A, "R5 new txn", wiperCode, 8'h5A);

    writeTxn(8'h00, 1, 8'h3C, "R6 setup ack");
    writeTxn(8'h20, 0, 8'h00, "R6 sd ack");
    check(shutdownOut, "R6 shutdown on", shutdownOut, 1);
    check(wiperCode == 8'h3C, "R6 code kept", wiperCode, 8'h3C);
    writeTxn(8'h20, 1, 8'h99, "R6 write in sd ack");
    check(shutdownOut && wiperCode == 8'h99, "R6 stored in sd", wiperCode, 8'h99);
    readTxn(8'h99, "R6 R7 read in sd");
    writeTxn(8'h00, 0, 8'h00, "R6 sd off ack");
    check(!shutdownOut, "R6 shutdown off", shutdownOut, 0);
    check(wiperCode == 8'h99, "R6 code after sd", wiperCode, 8'h99);

    writeTxn(8'h60, 1, 8'h12, "R5 R6 combined ack");
    check(shutdownOut && wiperCode == 8'h80, "R5 R6 combined", wiperCode, 8'h80);
    writeTxn(8'h9F, 1, 8'h44, "R9 dont care ack");
    check(!shutdownOut && wiperCode == 8'h44, "R9 dont care", wiperCode, 8'h44);

    busStart();
    writeByte(addrByte(strap, 1'b0), a0);
    writeByte(8'h00, a1);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStop();
    check(wiperCode == 8'h44, "R8 stop mid byte", wiperCode, 8'h44);

    busStart();
    writeByte(addrByte(strap, 1'b0), a0);
    writeByte(8'h00, a1);
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    check(wiperCode == 8'h44, "R8 partial no commit", wiperCode, 8'h44);
    busStart();
    writeByte(addrByte(strap, 1'b0), a0);
    writeByte(8'h00, a1);
    writeByte(8'h77, a2);
    busStop();
    check(a0 && a1 && a2, "R8 restart ack", {a0, a1, a2}, 3'b111);
    check(wiperCode == 8'h77, "R8 restart write", wiperCode, 8'h77);

    strap = 1'b1;
    repeat (4) @(negedge clk);
    writeTxn(8'h00, 1, 8'hA5, "R2 strap1 ack");
    check(wiperCode == 8'hA5, "R2 strap1 write", wiperCode, 8'hA5);
    busStart();
    writeByte(addrByte(1'b0, 1'b1), a0);
    busStop();
    check(!a0, "R2 strap1 mismatch", a0, 0);
    readTxn(8'hA5, "R2 R7 strap1 read");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule